// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

This block takes one fast input clock and derives two slower clocks from it. The primary clock is the input divided by 1, 2, 4 or 8, selected by a two-bit code. The secondary clock is produced by dividing the primary clock again by 4 or 8, selected by a one-bit code. Its total ratio to the input is therefore the product of the two factors, from 4 up to 64. Both divided clocks have an equal high and low time. In the divide-by-1 setting the input clock is passed straight through, gated only by the master reset.

Both dividers are state machines clocked by the input clock. The primary machine has the states IDLE (held in reset), HIGH, LOW and PASS (divide by 1). It moves IDLE→HIGH or IDLE→PASS on the first input edge after reset. It moves HIGH→LOW when its half-period counter runs out. From the end of LOW it goes to HIGH or PASS. From PASS it goes to PASS or HIGH. At each of these period starts it raises a one-cycle start strobe and takes in the current code. The secondary machine has the states IDLE, HIGH and LOW. It advances only on cycles that carry the primary start strobe, with the transitions IDLE→HIGH, HIGH→LOW and LOW→HIGH. It also takes in its code only when a new secondary period begins. A changed code therefore never cuts a high or low phase short.

Top module: `cascaded_clk_div`

## Requirements
- R1: With no code change pending, the primary clock repeats every 1, 2, 4 or 8 input cycles for a primary code of 00, 01, 10 or 11 respectively.
- R2: The secondary clock repeats every 4 primary periods when the secondary code is 0, and every 8 primary periods when it is 1.
- R3: For primary codes 01 to 11, the primary clock is high for exactly half its period, counted in input cycles, and low for the other half.
- R4: The secondary clock is high for exactly half of its period, counted in input cycles, and low for the other half.
- R5: With primary code 00, the primary clock equals the input clock whenever reset is inactive.
- R6: While the master reset is asserted, both outputs are low at once, without waiting for a clock edge. On the first rising input edge after release, both outputs start a new period, beginning with their high phase.
- R7: A new primary code takes effect only at the rising edge that ends a primary low phase (or ends a divide-by-1 cycle). The phase that is running completes with its old length.
- R8: A new secondary code takes effect only at the primary period start that ends a secondary low phase.
- R9: The secondary clock changes level only at rising input edges where a new primary period begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| mreset | input | 1 | Master reset, active high, asynchronous |
| n_code | input | 2 | Primary divide code (00:1, 01:2, 10:4, 11:8) |
| p_code | input | 1 | Secondary divide code (0:4, 1:8) |
| pri_clk | output | 1 | Primary divided clock |
| sec_clk | output | 1 | Secondary divided clock |

## Verification
A code change can arrive in the very input cycle where a primary period boundary and a secondary period boundary coincide. In that cycle both machines must reload together, and each must pick up the right code and no stale one. The bench provokes this in two ways. It moves through all eight code pairs, and it also runs a stretch in which both codes change pseudo-randomly on every cycle. Its behavioural model latches each code only at a period start and is compared on both clock phases of every cycle, so a reload taken one cycle early or late shows up as a mismatch. Measured high and low widths and an asynchronous reset taken during pass-through complete the judgement.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_PASS = 2'd3
    } div_state_e;

endpackage

// File: rtl/cdiv_primary.sv
module cdiv_primary
    import cdiv_pkg::*;
#(
    parameter int CODE_W = 2,
    parameter int HALF_W = 2
) (
    input  logic              clk_in,
    input  logic              mreset,
    input  logic [CODE_W-1:0] code_in,
    output logic              div_out,
    output logic              period_start
);

    div_state_e        state, state_nx;
    logic [HALF_W-1:0] half, half_nx;
    logic [CODE_W-1:0] code_act, code_nx;
    logic              level;

    // Cycles left in one half period, minus one; code 0 has no halves.
    function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] c);
        int h;
        h = (c == '0) ? 0 : ((1 << (int'(c) - 1)) - 1);
        return HALF_W'(h);
    endfunction

    always_comb begin
        state_nx     = state;
        half_nx      = half;
        code_nx      = code_act;
        period_start = 1'b0;
        unique case (state)
            ST_IDLE, ST_PASS: period_start = 1'b1;
            ST_HIGH: begin
                if (half == '0) begin
                    state_nx = ST_LOW;
                    half_nx  = half_of(code_act);
                end else begin
                    half_nx = half - HALF_W'(1);
                end
            end
            ST_LOW: begin
                if (half == '0) period_start = 1'b1;
                else            half_nx = half - HALF_W'(1);
            end
        endcase
        if (period_start) begin
            code_nx = code_in;
            if (code_in == '0) begin
                state_nx = ST_PASS;
                half_nx  = '0;
            end else begin
                state_nx = ST_HIGH;
                half_nx  = half_of(code_in);
            end
        end
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) begin
            state    <= ST_IDLE;
            half     <= '0;
            code_act <= '0;
        end else begin
            state    <= state_nx;
            half     <= half_nx;
            code_act <= code_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_HIGH: level = 1'b1;
            ST_PASS: level = clk_in;
            default: level = 1'b0;
        endcase
        div_out = level & ~mreset;
    end

    AST_PRI_HALF_BOUND: assert property (@(posedge clk_in) disable iff (mreset)
        (state == ST_HIGH || state == ST_LOW) |-> (half <= half_of(code_act))); // R3
    AST_PRI_CODE_HELD: assert property (@(posedge clk_in) disable iff (mreset)
        !period_start |=> $stable(code_act)); // R7
    AST_PRI_PASS_CODE: assert property (@(posedge clk_in) disable iff (mreset)
        (state == ST_PASS) |-> (code_act == '0)); // R5

endmodule

// File: rtl/cdiv_secondary.sv
module cdiv_secondary
    import cdiv_pkg::*;
#(
    parameter int CODE_W    = 1,
    parameter int BASE_LOG2 = 2,
    parameter int HALF_W    = 2
) (
    input  logic              clk_in,
    input  logic              mreset,
    input  logic              tick,
    input  logic [CODE_W-1:0] code_in,
    output logic              div_out
);

    div_state_e        state, state_nx;
    logic [HALF_W-1:0] half, half_nx;
    logic [CODE_W-1:0] code_act, code_nx;
    logic              start;

    // Primary periods left in one half period, minus one.
    function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] c);
        int h;
        h = (1 << (BASE_LOG2 + int'(c) - 1)) - 1;
        return HALF_W'(h);
    endfunction

    always_comb begin
        state_nx = state;
        half_nx  = half;
        code_nx  = code_act;
        start    = 1'b0;
        if (tick) begin
            unique case (state)
                ST_IDLE: start = 1'b1;
                ST_HIGH: begin
                    if (half == '0) begin
                        state_nx = ST_LOW;
                        half_nx  = half_of(code_act);
                    end else begin
                        half_nx = half - HALF_W'(1);
                    end
                end
                ST_LOW: begin
                    if (half == '0) start = 1'b1;
                    else            half_nx = half - HALF_W'(1);
                end
                default: state_nx = ST_IDLE;
            endcase
        end
        if (start) begin
            code_nx  = code_in;
            state_nx = ST_HIGH;
            half_nx  = half_of(code_in);
        end
    end

    always_ff @(posedge clk_in or posedge mreset) begin
        if (mreset) begin
            state    <= ST_IDLE;
            half     <= '0;
            code_act <= '0;
        end else begin
            state    <= state_nx;
            half     <= half_nx;
            code_act <= code_nx;
        end
    end

    always_comb begin
        div_out = (state == ST_HIGH) & ~mreset;
    end

    AST_SEC_TICK_ONLY: assert property (@(posedge clk_in) disable iff (mreset)
        !tick |=> ($stable(state) && $stable(half))); // R9
    AST_SEC_CODE_HELD: assert property (@(posedge clk_in) disable iff (mreset)
        !start |=> $stable(code_act)); // R8
    AST_SEC_NO_PASS: assert property (@(posedge clk_in) disable iff (mreset)
        state != ST_PASS); // R4

endmodule

// File: rtl/cascaded_clk_div.sv
module cascaded_clk_div #(
    parameter int PRI_CODE_W    = 2,
    parameter int SEC_CODE_W    = 1,
    parameter int SEC_BASE_LOG2 = 2
) (
    input  logic                  clk_in,
    input  logic                  mreset,
    input  logic [PRI_CODE_W-1:0] n_code,
    input  logic [SEC_CODE_W-1:0] p_code,
    output logic                  pri_clk,
    output logic                  sec_clk
);

    localparam int PRI_MAXLOG = (1 << PRI_CODE_W) - 1;
    localparam int PRI_HALF_W = (PRI_MAXLOG > 1) ? PRI_MAXLOG - 1 : 1;
    localparam int SEC_MAXLOG = SEC_BASE_LOG2 + (1 << SEC_CODE_W) - 1;
    localparam int SEC_HALF_W = (SEC_MAXLOG > 1) ? SEC_MAXLOG - 1 : 1;

    logic pri_tick;

    cdiv_primary #(
        .CODE_W (PRI_CODE_W),
        .HALF_W (PRI_HALF_W)
    ) u_pri (
        .clk_in       (clk_in),
        .mreset       (mreset),
        .code_in      (n_code),
        .div_out      (pri_clk),
        .period_start (pri_tick)
    );

    cdiv_secondary #(
        .CODE_W    (SEC_CODE_W),
        .BASE_LOG2 (SEC_BASE_LOG2),
        .HALF_W    (SEC_HALF_W)
    ) u_sec (
        .clk_in  (clk_in),
        .mreset  (mreset),
        .tick    (pri_tick),
        .code_in (p_code),
        .div_out (sec_clk)
    );

    always_comb begin
        if (mreset) begin
            AST_RST_OUTS_LOW: assert (!pri_clk && !sec_clk); // R6
        end
    end

    AST_SEC_RISE_ON_TICK: assert property (@(posedge clk_in) disable iff (mreset)
        !pri_tick |=> $stable(sec_clk)); // R9

endmodule

// File: tb/cascaded_clk_div_tb.sv
module cascaded_clk_div_tb;

    logic       clk_in = 1'b0;
    logic       mreset = 1'b1;
    logic [1:0] n_code = 2'd0;
    logic [0:0] p_code = 1'b0;
    logic       pri_clk, sec_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    bit started = 1'b0;
    int pr = 1, pcnt = 0, sr = 4, sidx = 0;

    // width tracking
    bit steady = 1'b0;
    int p_hi = 0, p_lo = 0, p_skip = 0;
    int s_hi = 0, s_lo = 0, s_skip = 0;

    cascaded_clk_div u_dut (
        .clk_in  (clk_in),
        .mreset  (mreset),
        .n_code  (n_code),
        .p_code  (p_code),
        .pri_clk (pri_clk),
        .sec_clk (sec_clk)
    );

    always #5 clk_in = ~clk_in;

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit new_pri;
        new_pri = 1'b0;
        if (mreset) begin
            started = 1'b0;
        end else if (!started) begin
            started = 1'b1;
            pr = 1 << n_code; pcnt = 0; new_pri = 1'b1;
            sr = p_code[0] ? 8 : 4; sidx = 0;
        end else begin
            pcnt++;
            if (pcnt == pr) begin
                pcnt = 0; pr = 1 << n_code; new_pri = 1'b1;
                sidx++;
                if (sidx == sr) begin
                    sidx = 0; sr = p_code[0] ? 8 : 4;
                end
            end
        end
    endtask

    function automatic logic exp_pri(bit hi_phase);
        if (!started) return 1'b0;
        if (pr == 1)  return hi_phase;
        return (pcnt < pr / 2);
    endfunction

    function automatic logic exp_sec();
        if (!started) return 1'b0;
        return (sidx < sr / 2);
    endfunction

    task automatic track(string tag, bit v, int wexp, inout int hi, inout int lo, inout int skip);
        if (v) begin
            if (lo > 0) begin
                if (skip > 0) skip--;
                else if (steady) check_int({tag, " low width"}, lo, wexp);
                lo = 0;
            end
            hi++;
        end else begin
            if (hi > 0) begin
                if (skip > 0) skip--;
                else if (steady) check_int({tag, " high width"}, hi, wexp);
                hi = 0;
            end
            lo++;
        end
    endtask

    task automatic cycle();
        @(posedge clk_in);
        model_edge();
        #2;
        check_bit("R1 R5 R7 primary high phase", pri_clk, exp_pri(1'b1));
        check_bit("R2 R8 R9 secondary", sec_clk, exp_sec());
        if (n_code != 2'd0)
            track("R3 primary", pri_clk, (1 << n_code) / 2, p_hi, p_lo, p_skip);
        track("R4 secondary", sec_clk, ((1 << n_code) * (p_code[0] ? 8 : 4)) / 2,
              s_hi, s_lo, s_skip);
        @(negedge clk_in);
        #2;
        check_bit("R1 R5 primary low phase", pri_clk, exp_pri(1'b0));
        check_bit("R2 R9 secondary low phase", sec_clk, exp_sec());
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        // reset state: outputs low, even in pass-through with the clock high (R6)
        repeat (3) cycle();
        @(negedge clk_in); #3;
        mreset = 1'b0;
        p_skip = 3; s_skip = 3;

        for (int n = 0; n < 4; n++) begin
            for (int p = 0; p < 2; p++) begin
                n_code = 2'(n);
                p_code = 1'(p);
                steady = 1'b1;
                p_skip = 3; s_skip = 3;
                repeat (220) cycle();
            end
        end

        // codes change every cycle: reloads must occur only at boundaries (R7 R8)
        steady = 1'b0;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            n_code = lf[1:0];
            p_code = lf[4];
            cycle();
        end

        // asynchronous reset during pass-through (R6 R5)
        n_code = 2'd0;
        p_code = 1'b0;
        repeat (20) cycle();
        mreset = 1'b1;
        #1;
        check_bit("R6 async primary low", pri_clk, 1'b0);
        check_bit("R6 async secondary low", sec_clk, 1'b0);
        repeat (3) cycle();
        n_code = 2'd2;
        p_code = 1'b1;
        mreset = 1'b0;
        @(posedge clk_in); model_edge(); #2;
        check_bit("R6 primary high after release", pri_clk, 1'b1);
        check_bit("R6 secondary high after release", sec_clk, 1'b1);
        @(negedge clk_in); #3;
        steady = 1'b1;
        p_skip = 1; s_skip = 1;
        p_hi = 0; p_lo = 0; s_hi = 0; s_lo = 0;
        repeat (150) cycle();

        finish_run();
    end

endmodule